// File: doc/BRIEF.md
# Bit-Serial Associative Extreme-Value Search

This block locates the largest or the smallest of N unsigned data words held side by side, one word per processing element. It keeps a single candidate bit for each element and narrows the candidate set one bit slice per clock cycle, starting at the most significant bit and finishing at the least significant. When the scan ends, every element whose candidate bit is still set holds the extreme value. Several set bits mean a tie; choosing one element among them is left to a separate resolution stage.

A search starts with a one-cycle start strobe. On that edge the block captures the data words, the mode (maximum or minimum) and a participation mask. Elements outside the mask begin with a cleared candidate bit and can never win. For each slice the candidate bits are ANDed with the slice bits (inverted for a minimum search). The candidate vector takes the AND result only when at least one bit of that result is set. Otherwise it keeps its old value. A completion flag pulses once when the last slice has been applied.

Top module: `amm_search`

## Requirements
- R1: While reset is low at a clock edge, the block clears the candidate vector, the busy flag and the done flag after that edge.
- R2: Start is accepted when the block is idle. After the edge that accepts it, busy is 1 and the candidate vector equals the participation mask (bit i = element i).
- R3: In maximum mode (find_min = 0), the final candidate vector has bit i set exactly for the participating elements whose word equals the largest participating word.
- R4: During a scan, a slice whose ANDed result is all zero leaves the candidate vector unchanged. A non-empty candidate set never becomes empty.
- R5: In minimum mode (find_min = 1), the final candidate vector has bit i set exactly for the participating elements whose word equals the smallest participating word.
- R6: done is 1 for exactly one cycle: the cycle after the W-th clock edge following the accepting edge. In that same cycle busy is 0 and the candidate vector is final.
- R7: With a participation mask of all zeros, the candidate vector stays all zero throughout the search and afterwards.
- R8: A start while busy is 1 is ignored. The running search completes on its original data, mask, mode and timing.
- R9: A non-participating element's candidate bit is never set.
- R10: Once idle, the candidate vector holds its value until the next accepted start or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search |
| find_min | input | 1 | 0 = maximum search, 1 = minimum search; captured at start |
| part_mask | input | N | Bit i = 1 lets element i take part; captured at start |
| data_flat | input | N*W | Element i occupies bits [i*W +: W]; captured at start |
| cand_mask | output | N | Candidate bits; after completion, marks all elements tied for the extreme |
| busy | output | 1 | High while slices are being scanned |
| done | output | 1 | One-cycle pulse when the final candidate vector is valid |

## Verification
Start is driven on a falling edge, so it is accepted on the next rising edge. The candidate vector and busy already show the loaded state at the following falling edge. The bench then counts W more falling edges, checks that done is 0 at each of the first W-1 and 1 at the W-th, and compares the final candidate vector at that W-th sample. One further sample confirms that done has dropped and that the candidate vector is unchanged. Reset takes effect one edge after it is sampled, so its effects are checked at the next falling edge.

// File: rtl/amm_pkg.sv
// Shared types for the extreme-value search block.
// Assumes: nothing beyond the standard language.
package amm_pkg;
    typedef enum logic {
        AMM_MAX = 1'b0,
        AMM_MIN = 1'b1
    } amm_mode_e;
endpackage

// File: rtl/amm_seq.sv
// Sequencer: accepts a start when idle, walks the slice index from W-1 down
// to 0 (one slice per cycle), then pulses done.
// Assumes: W >= 2.
module amm_seq #(
    parameter int W    = 8,
    localparam int IDXW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            launch,
    output logic            busy,
    output logic            done,
    output logic [IDXW-1:0] idx
);
    // accepted start: only when idle
    assign launch = start && !busy;

    // slice counter, busy flag and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                busy <= 1'b1;
                idx  <= IDXW'(W - 1);
            end else if (busy) begin
                if (idx == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/amm_slice.sv
// Slice evaluator: picks bit idx of every captured word, inverts it for a
// minimum search, ANDs it with the candidate bit, and reports whether any
// survivor remains.
// Assumes: words are packed element i at [i*W +: W].
module amm_slice
    import amm_pkg::*;
#(
    parameter int N    = 4,
    parameter int W    = 8,
    localparam int IDXW = $clog2(W)
) (
    input  logic [N*W-1:0] words,
    input  logic [IDXW-1:0] idx,
    input  amm_mode_e       mode,
    input  logic [N-1:0]    cand,
    output logic [N-1:0]    survive,
    output logic            any_left
);
    for (genvar i = 0; i < N; i++) begin : g_elem
        logic [W-1:0] word;
        logic         sbit;
        assign word = words[i*W +: W];
        // slice bit, complemented for minimum search
        assign sbit = (mode == AMM_MIN) ? ~word[idx] : word[idx];
        assign survive[i] = sbit & cand[i];
    end

    // at least one element still a candidate after this slice
    assign any_left = |survive;
endmodule

// File: rtl/amm_cand.sv
// Candidate register: loaded with the participation mask on launch, then
// replaced by the slice survivors only when at least one survives.
// Assumes: load and step are never both meaningful in the same cycle
// (load takes priority).
module amm_cand #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_val,
    input  logic         step,
    input  logic [N-1:0] survive,
    input  logic         any_left,
    output logic [N-1:0] cand
);
    // candidate bit update
    always_ff @(posedge clk) begin
        if (!rst_n)
            cand <= '0;
        else if (load)
            cand <= load_val;
        else if (step && any_left)
            cand <= survive;
    end
endmodule

// File: rtl/amm_search.sv
// Top: captures words, mode and mask on an accepted start, then eliminates
// candidates MSB first, one slice per cycle, for W cycles.
// Assumes: unsigned words; ties are resolved elsewhere.
module amm_search
    import amm_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8,
    localparam int IDXW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           find_min,
    input  logic [N-1:0]   part_mask,
    input  logic [N*W-1:0] data_flat,
    output logic [N-1:0]   cand_mask,
    output logic           busy,
    output logic           done
);
    logic            launch;
    logic [IDXW-1:0] idx;
    logic [N*W-1:0]  words_q;
    logic [N-1:0]    mask_q;
    amm_mode_e       mode_q;
    logic [N-1:0]    survive;
    logic            any_left;

    // operand capture on accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            mask_q  <= '0;
            mode_q  <= AMM_MAX;
        end else if (launch) begin
            words_q <= data_flat;
            mask_q  <= part_mask;
            mode_q  <= amm_mode_e'(find_min);
        end
    end

    amm_seq #(.W(W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .launch (launch),
        .busy   (busy),
        .done   (done),
        .idx    (idx)
    );

    amm_slice #(.N(N), .W(W)) u_slice (
        .words    (words_q),
        .idx      (idx),
        .mode     (mode_q),
        .cand     (cand_mask),
        .survive  (survive),
        .any_left (any_left)
    );

    amm_cand #(.N(N)) u_cand (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (part_mask),
        .step     (busy),
        .survive  (survive),
        .any_left (any_left),
        .cand     (cand_mask)
    );
endmodule

// File: rtl/amm_search_chk.sv
// Property checker for amm_search, attached by bind.
// Assumes: synchronous active-low reset.
module amm_search_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] cand_mask,
    input logic [N-1:0] part_mask,
    input logic [N-1:0] mask_q
);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && cand_mask == $past(part_mask)));

    p_keep_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cand_mask != '0) |=> (cand_mask != '0));

    p_shrink_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> ((cand_mask & ~$past(cand_mask)) == '0));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_outside_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((cand_mask & ~mask_q) == '0));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(cand_mask));
endmodule

bind amm_search amm_search_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .cand_mask (cand_mask),
    .part_mask (part_mask),
    .mask_q    (mask_q)
);

// File: tb/sim_amm_search.sv
// Bench for amm_search: vector table walk, then directed reset and
// overlap tests.
module sim_amm_search;
    localparam int N = 4;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int NV = 11;
    // entry: [40:9] words {e3,e2,e1,e0}, [8:5] mask, [4] min, [3:0] expected
    localparam logic [40:0] VEC [NV] = '{
        {8'd180, 8'd190, 8'd160, 8'd170, 4'b1111, 1'b0, 4'b0100},
        {8'd180, 8'd190, 8'd160, 8'd170, 4'b1111, 1'b1, 4'b0010},
        {8'd1,   8'd9,   8'd9,   8'd5,   4'b1111, 1'b0, 4'b0110},
        {8'd1,   8'd9,   8'd9,   8'd5,   4'b1111, 1'b1, 4'b1000},
        {8'd1,   8'd9,   8'd9,   8'd5,   4'b1001, 1'b0, 4'b0001},
        {8'd0,   8'd0,   8'd0,   8'd0,   4'b1111, 1'b0, 4'b1111},
        {8'd7,   8'd0,   8'd255, 8'd255, 4'b1111, 1'b1, 4'b0100},
        {8'd25,  8'd50,  8'd100, 8'd200, 4'b1110, 1'b0, 4'b0010},
        {8'd8,   8'd8,   8'd8,   8'd8,   4'b0101, 1'b1, 4'b0101},
        {8'd4,   8'd3,   8'd2,   8'd1,   4'b0000, 1'b0, 4'b0000},
        {8'd255, 8'd255, 8'd255, 8'd255, 4'b1000, 1'b1, 4'b1000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           find_min = 1'b0;
    logic [N-1:0]   part_mask = '0;
    logic [N*W-1:0] data_flat = '0;
    logic [N-1:0]   cand_mask;
    logic           busy;
    logic           done;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    amm_search #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .find_min(find_min),
        .part_mask(part_mask), .data_flat(data_flat),
        .cand_mask(cand_mask), .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // launch one search and follow it to completion
    task automatic run(input logic [31:0] d, input logic [3:0] m, input logic mn,
                       input logic [3:0] exp, input string req);
        logic [3:0] fin;
        @(negedge clk);
        data_flat = d; part_mask = m; find_min = mn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 32'(busy), 32'd1);
        check("R2 load mask", 32'(cand_mask), 32'(m));
        for (int i = 1; i <= W; i++) begin
            @(negedge clk);
            check("R6 done timing", 32'(done), 32'(i == W));
        end
        check(req, 32'(cand_mask), 32'(exp));
        check("R6 idle at done", 32'(busy), 32'd0);
        check("R9 outside mask", 32'(cand_mask & ~m), 32'd0);
        fin = cand_mask;
        @(negedge clk);
        check("R6 done one cycle", 32'(done), 32'd0);
        check("R10 hold", 32'(cand_mask), 32'(fin));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cand", 32'(cand_mask), 32'd0);
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R1 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][3:0] == 4'b0000)
                run(VEC[v][40:9], VEC[v][8:5], VEC[v][4], VEC[v][3:0], "R7 empty mask");
            else if (VEC[v][4])
                run(VEC[v][40:9], VEC[v][8:5], VEC[v][4], VEC[v][3:0], "R5 min result");
            else
                run(VEC[v][40:9], VEC[v][8:5], VEC[v][4], VEC[v][3:0], "R3 max result");
        end

        // R4: 190 eliminates the rest early; later zero slices must keep it
        run({8'd3, 8'd190, 8'd64, 8'd65}, 4'b1111, 1'b0, 4'b0100, "R4 zero slices keep");

        // R8: restart during a search is ignored
        @(negedge clk);
        data_flat = {8'd180, 8'd190, 8'd160, 8'd170}; part_mask = 4'b1111;
        find_min = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        data_flat = {8'd0, 8'd0, 8'd0, 8'd200}; part_mask = 4'b0001;
        find_min = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 still busy", 32'(busy), 32'd1);
        // accepted edge + 3 edges elapsed; W-3 remain
        repeat (W - 4) @(negedge clk);
        check("R8 no early done", 32'(done), 32'd0);
        @(negedge clk);
        check("R8 original timing", 32'(done), 32'd1);
        check("R8 original result", 32'(cand_mask), 32'b0100);

        // R1: reset in the middle of a search
        run({8'd1, 8'd2, 8'd3, 8'd4}, 4'b1111, 1'b1, 4'b1000, "R5 min result");
        @(negedge clk);
        start = 1'b1; part_mask = 4'b1111;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset cand", 32'(cand_mask), 32'd0);
        check("R1 mid reset busy", 32'(busy), 32'd0);
        rst_n = 1'b1;
        repeat (W + 2) @(negedge clk);
        check("R1 no done after reset", 32'(done), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule